// File: doc/BRIEF.md
# Tape Word Interval Timing Monitor

This block sits beside the data separator of a tape channel. The separator pulses a strobe each time a 12-bit word is assembled. The monitor measures the clock cycles between consecutive strobes against a lower and an upper limit. The nominal spacing is 133 µs, and anything from about half to twice that spacing is accepted. The block also tracks whether the memory-transfer side has acknowledged each word before the next one arrives. A word that comes too soon, a gap that grows too long and a word that lands while its predecessor is still unserviced are the three timing fault causes.

All causes feed one sticky timing error. The first fault moves the block into an abort state. There it holds the transfer-abort output high and ignores further strobes, so an erratic interval cannot go on to damage the tape format during a write. The cause flags keep the causes of the faulting cycle only, which shows what went wrong first. Dropping `enable` clears everything and re-arms the monitor. The first strobe after re-arming starts the measurement and is not itself checked.

The controller has four states:
- `ST_IDLE`: `enable` is low, or reset has just ended.
- `ST_ARMED`: the block is enabled and waits for the first strobe.
- `ST_RUN`: intervals are being measured.
- `ST_ABORT`: a fault has been seen and transfers are stopped.

The transitions are:
- IDLE→ARMED: `enable` is high and there is no strobe.
- IDLE→RUN: `enable` is high and a strobe arrives.
- ARMED→RUN: a strobe arrives.
- RUN→RUN: a strobe arrives and no fault is found.
- RUN→ABORT: any cause is detected.
- Any state→IDLE: `enable` is low.

Top module: `tape_word_timing_monitor`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `timing_err`, `err_fast`, `err_slow`, `err_late` and `xfer_abort` are all 0.
- R2: The first strobe after `enable` rises, or after reset with `enable` high, raises no cause, whatever its timing.
- R3: The interval is the number of clock edges from one accepted strobe cycle to the next. An interval k with `min_gap` ≤ k ≤ `max_gap` raises no cause, and this includes both limits.
- R4: A strobe whose interval k is below `min_gap` sets `err_fast`, visible in the cycle after that strobe.
- R5: If `max_gap` cycles pass after an accepted strobe and none of them carries a strobe, `err_slow` is set in the following cycle.
- R6: A strobe that arrives while the previous word is still unacknowledged sets `err_late`. An acknowledge in the same cycle as the strobe counts as service in time.
- R7: `timing_err` is the OR of the three cause flags. Causes detected in the same cycle are all recorded.
- R8: From the cycle after the first cause, `xfer_abort` is 1 and stays 1 while `enable` is high. Later strobes are ignored, and the cause flags do not change.
- R9: A cycle with `enable` low clears all flags and `xfer_abort` from the next cycle on. Monitoring then restarts as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Monitor enable; low clears and re-arms the block |
| word_strobe | input | 1 | One-cycle pulse per assembled 12-bit word |
| svc_ack | input | 1 | Memory-transfer side has taken the pending word |
| min_gap | input | CNT_W | Smallest accepted interval, in cycles |
| max_gap | input | CNT_W | Largest accepted interval, in cycles |
| timing_err | output | 1 | Sticky OR of all causes |
| err_fast | output | 1 | Word arrived too soon |
| err_slow | output | 1 | Word overdue |
| err_late | output | 1 | Word not serviced before the next one |
| xfer_abort | output | 1 | Transfers halted |

## Verification
The too-fast check and the late-service check both act on the same strobe, so the two can fire together. The bench provokes this with a strobe two cycles after its predecessor, while the predecessor is still unacknowledged. It expects both `err_fast` and `err_late` in the next cycle, with `err_slow` clear. A second test places the acknowledge exactly on the strobe cycle, and only the window check may decide that outcome. A behavioural model in the bench is compared with every output on every cycle.

// File: rtl/twm_pkg.sv
package twm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_ABORT = 2'd3
    } twm_state_e;

    typedef struct packed {
        logic fast;
        logic slow;
        logic late;
    } twm_cause_t;

endpackage

// File: rtl/twm_interval_ctr.sv
module twm_interval_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             restart,
    input  logic             advance,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= ONE;
        end else if (advance && !(&cnt_q)) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/twm_pending_trk.sv
module twm_pending_trk (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic accept,
    input  logic ack,
    output logic pend
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pend_q <= 1'b0;
        end else if (accept) begin
            pend_q <= 1'b1;
        end else if (ack) begin
            pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/twm_cause_eval.sv
module twm_cause_eval
    import twm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             check_en,
    input  logic             strobe,
    input  logic             ack,
    input  logic             pend,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] min_gap,
    input  logic [CNT_W-1:0] max_gap,
    output logic             hit,
    output twm_cause_t       flags
);
    twm_cause_t now_c;
    twm_cause_t flags_q;

    always_comb begin
        now_c      = '0;
        now_c.fast = check_en && strobe && (cnt < min_gap);
        now_c.slow = check_en && !strobe && (cnt >= max_gap);
        now_c.late = check_en && strobe && pend && !ack;
    end

    assign hit = now_c.fast | now_c.slow | now_c.late;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flags_q <= '0;
        end else if (check_en) begin
            flags_q <= flags_q | now_c;
        end
    end

    assign flags = flags_q;

    // R4: a too-fast flag only appears right after a strobe cycle
    a_r4_fast_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q.fast) |-> $past(strobe));

    // R5: a too-slow flag only appears right after a strobe-free cycle
    a_r5_slow_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q.slow) |-> $past(!strobe));

endmodule

// File: rtl/tape_word_timing_monitor.sv
module tape_word_timing_monitor
    import twm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             word_strobe,
    input  logic             svc_ack,
    input  logic [CNT_W-1:0] min_gap,
    input  logic [CNT_W-1:0] max_gap,
    output logic             timing_err,
    output logic             err_fast,
    output logic             err_slow,
    output logic             err_late,
    output logic             xfer_abort
);
    twm_state_e       state_q;
    twm_state_e       state_d;
    logic [CNT_W-1:0] cnt;
    logic             pend;
    logic             hit;
    twm_cause_t       flags;
    logic             clr;
    logic             accept;
    logic             advance;
    logic             check_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = word_strobe ? ST_RUN : ST_ARMED;
                ST_ARMED: state_d = word_strobe ? ST_RUN : ST_ARMED;
                ST_RUN:   state_d = hit ? ST_ABORT : ST_RUN;
                ST_ABORT: state_d = ST_ABORT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        clr        = !enable;
        check_en   = 1'b0;
        accept     = 1'b0;
        advance    = 1'b0;
        xfer_abort = 1'b0;
        if (enable) begin
            unique case (state_q)
                ST_IDLE, ST_ARMED: begin
                    accept = word_strobe;
                end
                ST_RUN: begin
                    check_en = 1'b1;
                    accept   = word_strobe && !hit;
                    advance  = !word_strobe;
                end
                ST_ABORT: begin
                    xfer_abort = 1'b1;
                end
                default: ;
            endcase
        end else begin
            xfer_abort = (state_q == ST_ABORT);
        end
    end

    twm_interval_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .restart (accept),
        .advance (advance),
        .cnt     (cnt)
    );

    twm_pending_trk u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .accept (accept),
        .ack    (svc_ack),
        .pend   (pend)
    );

    twm_cause_eval #(.CNT_W(CNT_W)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .check_en (check_en),
        .strobe   (word_strobe),
        .ack      (svc_ack),
        .pend     (pend),
        .cnt      (cnt),
        .min_gap  (min_gap),
        .max_gap  (max_gap),
        .hit      (hit),
        .flags    (flags)
    );

    assign err_fast   = flags.fast;
    assign err_slow   = flags.slow;
    assign err_late   = flags.late;
    assign timing_err = flags.fast | flags.slow | flags.late;

    // R7: any recorded cause comes with the abort state
    a_r7_err_implies_abort: assert property (@(posedge clk) disable iff (!rst_n)
        timing_err |-> xfer_abort);

    // R8: abort holds while enabled
    a_r8_abort_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_abort && enable) |=> xfer_abort);

    // R8: causes frozen once aborted
    a_r8_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_abort && enable) |=> $stable({err_fast, err_slow, err_late}));

    // R9: a disabled cycle clears error and abort
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!timing_err && !xfer_abort));

endmodule

// File: tb/tape_word_timing_monitor_bench.sv
module tape_word_timing_monitor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int WATCHDOG   = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             word_strobe = 1'b0;
    logic             svc_ack = 1'b0;
    logic [CNT_W-1:0] min_gap = 16'd4;
    logic [CNT_W-1:0] max_gap = 16'd8;
    logic             timing_err, err_fast, err_slow, err_late, xfer_abort;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string phase = "R1";

    // behavioural reference state
    int m_cnt     = 0;
    bit m_started = 0;
    bit m_pend    = 0;
    bit m_fast    = 0;
    bit m_slow    = 0;
    bit m_late    = 0;
    bit m_abort   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tape_word_timing_monitor #(.CNT_W(CNT_W)) u_tape_word_timing_monitor (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .word_strobe (word_strobe),
        .svc_ack     (svc_ack),
        .min_gap     (min_gap),
        .max_gap     (max_gap),
        .timing_err  (timing_err),
        .err_fast    (err_fast),
        .err_slow    (err_slow),
        .err_late    (err_late),
        .xfer_abort  (xfer_abort)
    );

    always @(posedge clk) begin
        bit f, s, l;
        cycles++;
        if (!rst_n || !enable) begin
            m_cnt = 0; m_started = 0; m_pend = 0;
            m_fast = 0; m_slow = 0; m_late = 0; m_abort = 0;
        end else if (m_abort) begin
            // frozen
        end else if (!m_started) begin
            if (word_strobe) begin
                m_started = 1; m_cnt = 1; m_pend = 1;
            end
        end else begin
            f = word_strobe && (m_cnt < int'(min_gap));
            l = word_strobe && m_pend && !svc_ack;
            s = !word_strobe && (m_cnt >= int'(max_gap));
            if (f || l || s) begin
                m_fast = f; m_slow = s; m_late = l; m_abort = 1;
            end else if (word_strobe) begin
                m_cnt = 1; m_pend = 1;
            end else begin
                m_cnt = m_cnt + 1;
                if (svc_ack) m_pend = 0;
            end
        end
    end

    task automatic check_bit(string what, logic act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", phase, what, act, exp, cycles);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            check_bit("err_fast",   err_fast,   m_fast);
            check_bit("err_slow",   err_slow,   m_slow);
            check_bit("err_late",   err_late,   m_late);
            check_bit("timing_err", timing_err, m_fast | m_slow | m_late);
            check_bit("xfer_abort", xfer_abort, m_abort);
        end
    end

    task automatic expect_out(bit f, bit s, bit l, bit a);
        check_bit("direct err_fast",   err_fast,   f);
        check_bit("direct err_slow",   err_slow,   s);
        check_bit("direct err_late",   err_late,   l);
        check_bit("direct timing_err", timing_err, f | s | l);
        check_bit("direct xfer_abort", xfer_abort, a);
    endtask

    task automatic idle(int n, bit ack_first);
        for (int i = 0; i < n; i++) begin
            svc_ack = ack_first && (i == 0);
            @(negedge clk);
        end
        svc_ack = 1'b0;
    endtask

    // strobe cycle; outputs sampled at the following negedge
    task automatic strobe(bit ack_same);
        word_strobe = 1'b1;
        svc_ack = ack_same;
        @(negedge clk);
        word_strobe = 1'b0;
        svc_ack = 1'b0;
    endtask

    // next word k cycles after the previous strobe
    task automatic word(int k, bit ack_between, bit ack_same);
        idle(k - 1, ack_between);
        strobe(ack_same);
    endtask

    task automatic rearm();
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        phase = "R1";
        expect_out(0, 0, 0, 0);
        rst_n = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        expect_out(0, 0, 0, 0);

        phase = "R2";                 // first word unchecked
        strobe(0);
        expect_out(0, 0, 0, 0);

        phase = "R3";                 // both window limits and a middle value
        word(4, 1, 0);
        expect_out(0, 0, 0, 0);
        word(8, 1, 0);
        expect_out(0, 0, 0, 0);
        word(6, 1, 0);
        expect_out(0, 0, 0, 0);

        phase = "R6";                 // ack on the strobe cycle counts as service
        word(5, 0, 1);
        expect_out(0, 0, 0, 0);

        phase = "R4";
        word(3, 1, 0);
        expect_out(1, 0, 0, 1);

        phase = "R8";                 // strobes ignored while aborted
        word(5, 1, 0);
        word(2, 0, 0);
        idle(12, 0);
        expect_out(1, 0, 0, 1);

        phase = "R9";
        enable = 1'b0;
        @(negedge clk);
        expect_out(0, 0, 0, 0);
        enable = 1'b1;
        phase = "R2";
        strobe(0);                    // immediately after re-arm
        expect_out(0, 0, 0, 0);

        phase = "R5";                 // eight quiet cycles: slow at the ninth
        idle(7, 1);
        expect_out(0, 0, 0, 0);
        idle(1, 0);
        expect_out(0, 1, 0, 1);

        phase = "R6";
        rearm();
        strobe(0);
        word(5, 0, 0);
        expect_out(0, 0, 1, 1);

        phase = "R7";                 // fast and late in the same cycle
        rearm();
        strobe(0);
        word(2, 0, 0);
        expect_out(1, 0, 1, 1);

        phase = "R3";                 // changed window limits
        rearm();
        min_gap = 16'd2;
        max_gap = 16'd3;
        strobe(0);
        word(2, 1, 0);
        word(3, 1, 0);
        expect_out(0, 0, 0, 0);
        idle(3, 1);
        phase = "R5";
        expect_out(0, 1, 0, 1);

        phase = "R1";
        rst_n = 1'b0;
        @(negedge clk);
        expect_out(0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        if (!done && cycles > WATCHDOG) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog %s: actual %0d cycles expected under %0d", phase, cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule